// File: doc/BRIEF.md
# Pause-Width Reader Frame Transmitter

This block turns a reader-to-card frame of up to 32 bits into a waveform on one modulation line. Every bit opens with a fixed low pause and then goes back high. The bit value sets how long the whole bit lasts: a one is long and a zero is short. When the last bit is done, one more low pause marks the end of the frame.

All edges are timed against a free-running microsecond counter supplied from outside. A scheduled time is built up from the end time of the previous frame: each interval is added to the stored schedule, not to the moment an edge was actually seen, so latency never adds up across a frame. The frame goes out a fixed slot delay after the timestamp that came in. When it finishes, the final scheduled time is presented so the receive side can carry on from it. A step pulse for each bit drives an external keystream generator.

Top module: `pause_frame_tx`

## Requirements
- R1: Out of reset, mod_o is high, busy_o, done_o and step_o are low, and ts_o is zero. mod_o is high whenever the block is idle.
- R2: A start_i pulse while idle captures frame_i, len_i and ts_i. busy_o is high from the next cycle until the cycle done_o pulses. The first low edge happens when now_i reaches ts_i + 220.
- R3: Each bit begins with mod_o low for 20 us. mod_o is then driven high again.
- R4: A bit of value 1 lasts 100 us from its falling edge to the next falling edge. A bit of value 0 lasts 60 us.
- R5: Bits go out from frame_i bit 0 upward, len_i bits in total. A length of 0 sends only the closing pause. Lengths above 32 behave as 32.
- R6: After the last bit, mod_o is low for 20 us and then rises. done_o pulses high for exactly one cycle, in the cycle the line rises.
- R7: step_o pulses exactly once per bit, for one cycle, in the cycle that bit ends and the next pause falls.
- R8: Each edge is scheduled at the previous scheduled time plus its interval, even when an earlier edge came late. ts_o takes the final rising-edge time when done_o pulses and changes at no other time.
- R9: start_i is ignored while busy_o is high. The frame in flight keeps its bits, timing and step count.
- R10: Time comparison uses the signed 32-bit difference now_i - target, so schedules that cross the counter wrap keep their exact spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | 32 | Free-running microsecond counter |
| start_i | input | 1 | Start strobe, one cycle |
| frame_i | input | 32 | Frame bits, bit 0 sent first |
| len_i | input | 6 | Number of bits to send |
| ts_i | input | 32 | End time of the previous frame |
| mod_o | output | 1 | Modulation line, low during pauses |
| step_o | output | 1 | Keystream advance pulse, one per bit |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete, one-cycle pulse |
| ts_o | output | 32 | End time of the frame just sent |

## Verification
Every internal error in this block shows up as a shifted edge on mod_o, so each edge is timed against the counter value that was scheduled for it. A wrong target register shows up at the very next edge. A wrong bit in the shift register or a wrong count shows up within one bit period, as a 60 us bit where 100 us was due or as a missing or extra step pulse. A schedule that follows observed time instead of stored time is exposed by a frame whose slot is already in the past: its first rise must come 20 us after the stored slot time, not 20 us after the late fall. A comparison that ignores wrap is exposed by a frame that crosses the top of the counter.

// File: rtl/pftx_pkg.sv
package pftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_PAUSE,
    ST_MARK,
    ST_TAIL
  } tx_state_e;
endpackage

// File: rtl/pftx_sched.sv
module pftx_sched #(
  parameter int TS_W = 32,
  parameter int T_SLOT = 220
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] now_i,
  input  logic            load_i,
  input  logic [TS_W-1:0] base_i,
  input  logic            add_i,
  input  logic [TS_W-1:0] delta_i,
  output logic [TS_W-1:0] target_o,
  output logic            due_o
);
  logic [TS_W-1:0] target_q;
  logic [TS_W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) target_q <= '0;
    else if (load_i) target_q <= base_i + TS_W'(T_SLOT);
    else if (add_i) target_q <= target_q + delta_i;
  end

  // signed distance survives counter wrap
  assign diff     = now_i - target_q;
  assign due_o    = ~diff[TS_W-1];
  assign target_o = target_q;

  p_target_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> target_q != $past(target_q));
endmodule

// File: rtl/pftx_bits.sv
module pftx_bits #(
  parameter int FRAME_W = 32,
  parameter int LEN_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               last_o,
  output logic               empty_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [LEN_W-1:0]   len_clamped;

  assign len_clamped = (len_i > LEN_W'(FRAME_W)) ? LEN_W'(FRAME_W) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= frame_i;
      cnt_q <= len_clamped;
    end else if (shift_i) begin
      sr_q  <= sr_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sr_q[0];
  assign last_o  = (cnt_q == LEN_W'(1));
  assign empty_o = (cnt_q == '0);

  p_shift_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> cnt_q != '0);
  p_load_drained_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0);
endmodule

// File: rtl/pftx_ctrl.sv
module pftx_ctrl
  import pftx_pkg::*;
#(
  parameter int TS_W = 32,
  parameter int T_PAUSE = 20,
  parameter int T_ONE = 100,
  parameter int T_ZERO = 60
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            due_i,
  input  logic            bit_i,
  input  logic            last_i,
  input  logic            empty_i,
  output logic            load_o,
  output logic            add_o,
  output logic [TS_W-1:0] delta_o,
  output logic            shift_o,
  output logic            fire_o,
  output logic            mod_o,
  output logic            step_o,
  output logic            done_o,
  output logic            busy_o
);
  localparam logic [TS_W-1:0] D_PAUSE = TS_W'(T_PAUSE);
  localparam logic [TS_W-1:0] D_ONE   = TS_W'(T_ONE - T_PAUSE);
  localparam logic [TS_W-1:0] D_ZERO  = TS_W'(T_ZERO - T_PAUSE);

  tx_state_e state_q, state_d;
  logic mod_q, mod_d, step_q, step_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    mod_d   = mod_q;
    step_d  = 1'b0;
    done_d  = 1'b0;
    load_o  = 1'b0;
    add_o   = 1'b0;
    delta_o = D_PAUSE;
    shift_o = 1'b0;
    fire_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = ST_SLOT;
      end
      ST_SLOT: if (due_i) begin
        add_o   = 1'b1;
        mod_d   = 1'b0;
        state_d = empty_i ? ST_TAIL : ST_PAUSE;
      end
      ST_PAUSE: if (due_i) begin
        add_o   = 1'b1;
        delta_o = bit_i ? D_ONE : D_ZERO;
        mod_d   = 1'b1;
        state_d = ST_MARK;
      end
      ST_MARK: if (due_i) begin
        add_o   = 1'b1;
        mod_d   = 1'b0;
        step_d  = 1'b1;
        shift_o = 1'b1;
        state_d = last_i ? ST_TAIL : ST_PAUSE;
      end
      ST_TAIL: if (due_i) begin
        mod_d   = 1'b1;
        done_d  = 1'b1;
        fire_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mod_q   <= 1'b1;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mod_q   <= mod_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign mod_o  = mod_q;
  assign step_o = step_q;
  assign done_o = done_q;
  assign busy_o = (state_q != ST_IDLE);

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mod_o);
  p_step_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !mod_o);
  p_done_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mod_o);
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int TS_W = 32,
  parameter int FRAME_W = 32,
  parameter int T_PAUSE = 20,
  parameter int T_ONE = 100,
  parameter int T_ZERO = 60,
  parameter int T_SLOT = 220,
  localparam int LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TS_W-1:0]    now_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [TS_W-1:0]    ts_i,
  output logic               mod_o,
  output logic               step_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [TS_W-1:0]    ts_o
);
  logic load, add, shift, fire, due, cur_bit, last, empty;
  logic [TS_W-1:0] delta, target, ts_q;

  pftx_sched #(.TS_W(TS_W), .T_SLOT(T_SLOT)) u_sched (
    .clk_i, .rst_ni, .now_i,
    .load_i(load), .base_i(ts_i), .add_i(add), .delta_i(delta),
    .target_o(target), .due_o(due)
  );

  pftx_bits #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_bits (
    .clk_i, .rst_ni,
    .load_i(load), .frame_i, .len_i, .shift_i(shift),
    .bit_o(cur_bit), .last_o(last), .empty_o(empty)
  );

  pftx_ctrl #(.TS_W(TS_W), .T_PAUSE(T_PAUSE), .T_ONE(T_ONE), .T_ZERO(T_ZERO)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .due_i(due), .bit_i(cur_bit), .last_i(last), .empty_i(empty),
    .load_o(load), .add_o(add), .delta_o(delta), .shift_o(shift), .fire_o(fire),
    .mod_o, .step_o, .done_o, .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else if (fire) ts_q <= target;
  end
  assign ts_o = ts_q;

  p_ts_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ts_o) |-> done_o);
endmodule

// File: tb/sim_pause_frame_tx.sv
module sim_pause_frame_tx;
  typedef struct packed {
    logic [31:0] frame;
    logic [5:0]  len;
    logic [31:0] off;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_00A5, 6'd8,  32'd0},
    '{32'h0000_0001, 6'd1,  32'd5},
    '{32'hFFFF_FFFF, 6'd32, 32'd0},
    '{32'h0000_0000, 6'd12, 32'd3},
    '{32'h0000_002D, 6'd6,  -32'sd100},
    '{32'h1234_5678, 6'd0,  32'd0},
    '{32'h0000_0003, 6'd40, 32'd0}
  };
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] frame = '0, ts_in = '0, now_base = '0, now;
  logic [5:0] len = '0;
  logic mod, step, busy, done;
  logic [31:0] ts_out;
  int cyc = 0, steps_total = 0, checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (step) steps_total <= steps_total + 1;
  assign now = now_base + 32'(cyc);

  pause_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now), .start_i(start),
    .frame_i(frame), .len_i(len), .ts_i(ts_in),
    .mod_o(mod), .step_o(step), .busy_o(busy), .done_o(done), .ts_o(ts_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // edge time = counter value the design saw at the edge that moved mod
  task automatic wait_edge(input logic lvl, input logic [31:0] exp, input bit exact,
                           input bit want_step, input string tag);
    int n = 0;
    logic [31:0] t;
    do begin
      @(negedge clk);
      n++;
    end while (mod !== lvl && n < 2000);
    t = now - 32'd1;
    if (exact) chk(t == exp && mod === lvl, tag, t, exp);
    if (want_step) chk(step === 1'b1, "R7 step at bit end", 32'(step), 32'd1);
  endtask

  task automatic run_frame(input logic [31:0] f, input logic [5:0] l, input logic [31:0] off,
                           input bit inject, input bit late, input string first_tag);
    logic [31:0] sched;
    int nb, s0;
    nb = (l > 6'd32) ? 32 : int'(l);
    @(negedge clk);
    s0 = steps_total;
    ts_in = now + off;
    frame = f; len = l; start = 1'b1;
    sched = ts_in + 32'd220;
    @(negedge clk);
    start = 1'b0;
    frame = ~f;
    ts_in = 32'h0BAD_0000;
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    wait_edge(1'b0, sched, !late, 1'b0, first_tag);
    for (int i = 0; i < nb; i++) begin
      sched += 32'd20;
      wait_edge(1'b1, sched, 1'b1, 1'b0, "R3 pause width");
      if (inject && i == 0) begin
        @(negedge clk);
        start = 1'b1; len = 6'd3; frame = 32'h7;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 start ignored", 32'(busy), 32'd1);
      end
      sched += f[i] ? 32'd80 : 32'd40;
      wait_edge(1'b0, sched, 1'b1, 1'b1, "R4 bit length / R5 order");
    end
    sched += 32'd20;
    wait_edge(1'b1, sched, 1'b1, 1'b0, "R6 trailing pause");
    chk(done === 1'b1, "R6 done with rise", 32'(done), 32'd1);
    chk(ts_out == sched, "R8 ts_o end time", ts_out, sched);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    chk(busy === 1'b0, "R2 idle after done", 32'(busy), 32'd0);
    chk(steps_total - s0 == nb, "R7 step count", 32'(steps_total - s0), 32'(nb));
    chk(ts_out == sched, "R8 ts_o held", ts_out, sched);
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL R2 watchdog: cycles %0d expected < %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mod === 1'b1, "R1 mod high in reset", 32'(mod), 32'd1);
    chk(busy === 1'b0 && done === 1'b0 && step === 1'b0, "R1 flags low", {busy, done, step}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ts_out == 32'd0, "R1 ts_o zero", ts_out, 32'd0);
    chk(mod === 1'b1, "R1 idle high", 32'(mod), 32'd1);

    for (int v = 0; v < NV; v++)
      run_frame(VECS[v].frame, VECS[v].len, VECS[v].off, 1'b0, 1'b0, "R2 slot delay");

    // R9: second start mid-frame must not disturb the frame in flight
    run_frame(32'h0000_0016, 6'd5, 32'd0, 1'b1, 1'b0, "R2 slot delay");

    // R8: slot already in the past; rise must follow the stored schedule
    run_frame(32'h0000_0002, 6'd3, -32'sd230, 1'b0, 1'b1, "R8 late slot");

    // R10: schedule crosses the counter wrap
    @(negedge clk);
    now_base = 32'hFFFF_FF00 - 32'(cyc);
    run_frame(32'h0000_0005, 6'd4, 32'd0, 1'b0, 1'b0, "R10 wrap slot");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule